// File: doc/BRIEF.md
# TLB Replacement Counter Register

This block is the control register that chooses which entry of a 64-entry unified translation buffer a software TLB-load instruction overwrites. It holds two 6-bit fields: a replacement counter and a replacement boundary. Every TLB access moves the counter forward by one. When the boundary is nonzero, the counter returns to zero once it reaches the boundary. This keeps replacement inside the lower part of the buffer, so software can hold entries above the boundary in place. A zero boundary lets the counter run through all 64 values.

Software reads and writes the whole register through a 32-bit port. The counter value is always present on the replacement index output. A TLB-load strobe freezes the counter for that cycle, so the load uses the index that is shown. The same register also carries a store-queue privilege bit and a virtual-memory mode bit. The privilege bit combines with a user-mode input and a store-queue access strobe to produce a one-cycle address-error pulse.

Top module: `tlb_repl_reg`

## Requirements
- R1: After reset, the read data, the replacement index, both mode outputs and the address-error output are all zero.
- R2: The boundary field is at bits 23:18 and the counter field is at bits 15:10. The store-queue privilege bit is bit 9 and the virtual-memory mode bit is bit 8. A register write loads every one of them, and a read returns the values held.
- R3: Bits 31:24, 17:16 and 7:0 always read as zero, and writing ones to them changes nothing.
- R4: On a TLB access without a load, the counter rises by one, unless the boundary is nonzero and the counter equals it.
- R5: With a nonzero boundary and the counter equal to it, a TLB access clears the counter to zero.
- R6: With a zero boundary, the counter steps through all 64 values and wraps from 63 to 0.
- R7: If software writes a counter value above the boundary, accesses take it up to 63 and then to 0. From there, wrapping at the boundary applies again.
- R8: A TLB-load strobe holds the counter for that cycle, even when an access happens in the same cycle. The replacement index output always equals the counter field.
- R9: When a register write and a TLB access fall in the same cycle, the counter takes the written value.
- R10: The address-error output is high in the cycle after one in which a store-queue access, user mode and a privilege bit of 1 are all present. It is low otherwise.
- R11: The output sq_priv_only follows bit 9 and the output single_vm follows bit 8 (0 = multiple, 1 = single virtual memory mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Current register image |
| tlb_access | input | 1 | One TLB access this cycle |
| tlb_load | input | 1 | TLB-load instruction this cycle |
| repl_idx | output | 6 | Entry index for replacement |
| sq_priv_only | output | 1 | Store queue restricted to privileged mode |
| single_vm | output | 1 | Single virtual memory mode selected |
| user_mode | input | 1 | Current access is from user mode |
| sq_access | input | 1 | Store-queue access this cycle |
| sq_addr_err | output | 1 | One-cycle address-error pulse |

## Verification
The bench builds the block with its default parameters: a 6-bit index for a 64-entry buffer and a 32-bit register port. With these values a run of accesses from zero reaches the natural wrap from 63 to 0. A written counter above a small boundary exercises the run-out to 63 and the return to boundary wrapping. The bench also drives a load, a write and an access in the same cycle, so the priority between the three sources is tested at the exact field positions software decodes.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned FLD_W    = 6;
  localparam int unsigned BND_LSB  = 18;
  localparam int unsigned CNT_LSB  = 10;
  localparam int unsigned SQ_BIT   = 9;
  localparam int unsigned VM_BIT   = 8;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tlb_repl_counter.sv
module tlb_repl_counter #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_cnt,
  input  logic [IDX_W-1:0] bnd,
  input  logic             access,
  input  logic             load,
  output logic [IDX_W-1:0] cnt
);
  localparam logic [IDX_W-1:0] ZERO = '0;
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             at_bnd, step, cnt_en;

  always_comb begin
    at_bnd = (bnd != ZERO) && (cnt_q == bnd);
    step   = access && !load;
    cnt_en = wr_en || step;
    cnt_d  = cnt_q;
    if (wr_en)       cnt_d = wr_cnt;
    else if (at_bnd) cnt_d = ZERO;
    else             cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !load && !wr_en && !((bnd != ZERO) && (cnt == bnd)))
      |=> (cnt == $past(cnt) + ONE));

  assert_wrap_at_bnd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !load && !wr_en && (bnd != ZERO) && (cnt == bnd)) |=> (cnt == ZERO));

  assert_hold_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> $stable(cnt));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_cnt)));
endmodule

// File: rtl/tlb_sq_guard.sv
module tlb_sq_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_priv,
  input  logic user_mode,
  input  logic sq_access,
  output logic err
);
  logic err_q, err_d;

  always_comb err_d = sq_access && user_mode && sq_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  assert_err_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_access && user_mode && sq_priv) |=> err);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_access && user_mode && sq_priv) |=> !err);
endmodule

// File: rtl/tlb_repl_reg.sv
module tlb_repl_reg
  import tlb_repl_pkg::*;
#(
  parameter int unsigned IDX_W = FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic              tlb_access,
  input  logic              tlb_load,
  output logic [IDX_W-1:0]  repl_idx,
  output logic              sq_priv_only,
  output logic              single_vm,
  input  logic              user_mode,
  input  logic              sq_access,
  output logic              sq_addr_err
);
  localparam logic [REG_W-1:0] FLD_MASK  = REG_W'({IDX_W{1'b1}});
  localparam logic [REG_W-1:0] USED_MASK = (FLD_MASK << BND_LSB) | (FLD_MASK << CNT_LSB)
                                         | (REG_W'(1) << SQ_BIT) | (REG_W'(1) << VM_BIT);

  logic             rst_sync_n;
  logic [IDX_W-1:0] bnd_q, bnd_d, cnt;
  logic             sq_q, sq_d, vm_q, vm_d;
  logic             unused_wr;

  tlb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    bnd_d = reg_wr_data[BND_LSB +: IDX_W];
    sq_d  = reg_wr_data[SQ_BIT];
    vm_d  = reg_wr_data[VM_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bnd_q <= '0;
      sq_q  <= 1'b0;
      vm_q  <= 1'b0;
    end else if (reg_wr_en) begin
      bnd_q <= bnd_d;
      sq_q  <= sq_d;
      vm_q  <= vm_d;
    end
  end

  tlb_repl_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr_en),
    .wr_cnt(reg_wr_data[CNT_LSB +: IDX_W]), .bnd(bnd_q),
    .access(tlb_access), .load(tlb_load), .cnt(cnt)
  );

  tlb_sq_guard u_sq (
    .clk(clk), .rst_n(rst_sync_n), .sq_priv(sq_q),
    .user_mode(user_mode), .sq_access(sq_access), .err(sq_addr_err)
  );

  always_comb begin
    reg_rd_data                    = '0;
    reg_rd_data[BND_LSB +: IDX_W]  = bnd_q;
    reg_rd_data[CNT_LSB +: IDX_W]  = cnt;
    reg_rd_data[SQ_BIT]            = sq_q;
    reg_rd_data[VM_BIT]            = vm_q;
  end

  assign repl_idx     = cnt;
  assign sq_priv_only = sq_q;
  assign single_vm    = vm_q;
  assign unused_wr    = ^(reg_wr_data & ~USED_MASK);

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd_data & ~USED_MASK) == '0);

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_en |=> (reg_rd_data == ($past(reg_wr_data) & USED_MASK)));

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_wr_en |=> ($stable(sq_priv_only) && $stable(single_vm)));
endmodule

// File: tb/tlb_repl_reg_test.sv
`timescale 1ns/1ps
module tlb_repl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, tlb_access, tlb_load, user_mode, sq_access;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic [5:0]  repl_idx;
  logic        sq_priv_only, single_vm, sq_addr_err;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_cnt, m_bnd, m_sq, m_vm, m_err;

  always #2 clk = ~clk;

  tlb_repl_reg uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .tlb_access(tlb_access), .tlb_load(tlb_load),
    .repl_idx(repl_idx), .sq_priv_only(sq_priv_only), .single_vm(single_vm),
    .user_mode(user_mode), .sq_access(sq_access), .sq_addr_err(sq_addr_err)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    longint img;
    img = (longint'(m_bnd) << 18) | (longint'(m_cnt) << 10) | (longint'(m_sq) << 9) | (longint'(m_vm) << 8);
    chk(tag, "rd_data", reg_rd_data, img);
    chk("R8", "repl_idx", repl_idx, m_cnt);
    chk("R11", "sq_priv_only", sq_priv_only, m_sq);
    chk("R11", "single_vm", single_vm, m_vm);
    chk("R10", "sq_addr_err", sq_addr_err, m_err);
  endtask

  // Drive one cycle of inputs, advance the model at the edge, compare at the next falling edge.
  task automatic cyc(input string tag, input bit wr, input logic [31:0] wd,
                     input bit acc, input bit ld, input bit usr, input bit sqa);
    reg_wr_en = wr; reg_wr_data = wd; tlb_access = acc; tlb_load = ld;
    user_mode = usr; sq_access = sqa;
    @(posedge clk);
    m_err = (sqa && usr && m_sq == 1) ? 1 : 0;
    if (wr) begin
      m_cnt = int'(wd[15:10]); m_bnd = int'(wd[23:18]);
      m_sq = int'(wd[9]); m_vm = int'(wd[8]);
    end else if (acc && !ld) begin
      if (m_bnd != 0 && m_cnt == m_bnd) m_cnt = 0;
      else m_cnt = (m_cnt + 1) % 64;
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] img(input int bnd, input int cnt, input bit sq, input bit vm);
    return (32'(bnd) << 18) | (32'(cnt) << 10) | (32'(sq) << 9) | (32'(vm) << 8);
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr_en = 0; reg_wr_data = '0; tlb_access = 0; tlb_load = 0; user_mode = 0; sq_access = 0;
    m_cnt = 0; m_bnd = 0; m_sq = 0; m_vm = 0; m_err = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");

    // R2 / R3: all ones written, reserved bits must read zero.
    cyc("R3", 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R3", "reserved bits", reg_rd_data & 32'hFF03_00FF, 0);
    cyc("R2", 1, img(9, 33, 0, 1), 0, 0, 0, 0);
    chk("R2", "counter field", reg_rd_data[15:10], 33);
    cyc("R2", 1, 32'h0, 0, 0, 0, 0);

    // R6: zero boundary runs the full range and wraps.
    for (int i = 0; i < 70; i++) cyc("R6", 0, '0, 1, 0, 0, 0);
    chk("R6", "after 70 steps", repl_idx, 6);

    // R4 / R5: boundary 5.
    cyc("R4", 1, img(5, 0, 0, 0), 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) cyc("R5", 0, '0, 1, 0, 0, 0);
    chk("R5", "after 14 steps bnd 5", repl_idx, 2);

    // R7: counter written above boundary.
    cyc("R7", 1, img(5, 60, 0, 0), 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R7", 0, '0, 1, 0, 0, 0);
    chk("R7", "wrap past 63", repl_idx, 0);
    for (int i = 0; i < 7; i++) cyc("R7", 0, '0, 1, 0, 0, 0);
    chk("R7", "boundary resumes", repl_idx, 1);

    // R8: load holds, with and without access.
    cyc("R8", 0, '0, 1, 1, 0, 0);
    cyc("R8", 0, '0, 0, 1, 0, 0);
    chk("R8", "held by load", repl_idx, 1);

    // R9: write and access in one cycle.
    cyc("R9", 1, img(0, 40, 0, 0), 1, 0, 0, 0);
    chk("R9", "write wins", repl_idx, 40);
    cyc("R9", 1, img(7, 7, 1, 0), 1, 1, 0, 0);

    // R10: address error only for user access with privilege bit set.
    cyc("R10", 0, '0, 0, 0, 1, 1);
    chk("R10", "error pulse", sq_addr_err, 1);
    cyc("R10", 0, '0, 0, 0, 0, 1);
    chk("R10", "privileged access", sq_addr_err, 0);
    cyc("R10", 0, '0, 0, 0, 1, 0);
    cyc("R10", 1, img(7, 7, 0, 1), 0, 0, 0, 0);
    cyc("R10", 0, '0, 0, 0, 1, 1);
    chk("R10", "bit clear, no error", sq_addr_err, 0);
    chk("R11", "single vm", single_vm, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule